// File: doc/BRIEF.md
# Host-Side Stepping Line-Rate Negotiator

This block controls rate negotiation for one serial storage port that faces an upstream host controller. It first waits for the host's reset burst and answers with its own init burst. It then waits for the host's wake burst and answers with a wake burst. After that it sends alignment primitives at the fast rate (3.0 Gbps) and waits for the host to confirm. If no confirming primitive arrives within a programmable number of timer ticks, it drops to the slow rate (1.5 Gbps) and tries again. If the slow attempt also times out, it reports failure for one cycle and goes back to waiting for a new reset burst.

The serializer, the clock recovery and the out-of-band burst detectors sit outside this block. It receives their events as single-cycle strobes and returns burst requests, a transmit rate select and a pattern select. By default the port negotiates its own rate. A configuration bit can tie it to the rate the downstream side already negotiated, so both sides end up at a common rate. A second configuration bit caps the port at the slow rate.

Top module: `host_rate_stepper`

## Requirements
- R1: After reset the block is idle: `link_up`=0, `neg_fail`=0, both burst requests 0, `pat_sel`=0 (electrical idle) and `tx_rate_hi`=1.
- R2: A reset-burst strobe (`oob_reset_seen`) received while idle makes `oob_init_req` high for exactly the next cycle. After that the block waits for the wake burst with `pat_sel`=0.
- R3: Alignment is never sent before the wake exchange. A wake strobe received while waiting makes `oob_wake_req` high for one cycle. In the cycle after that, `pat_sel`=1 (alignment). An alignment strobe or a wake strobe received while idle, or an alignment strobe received while waiting for the wake burst, changes no output.
- R4: An alignment strobe (`align_seen`) during an attempt moves the block to ready in the next cycle. Ready means `link_up`=1, `pat_sel`=2 (data) and `neg_rate_hi` equal to the rate of that attempt.
- R5: With no cap in effect, the first attempt uses `tx_rate_hi`=1. The rate stays at 1 through the first `cfg_window`-1 ticks. The tick that completes the window, if no alignment came before it, switches `tx_rate_hi` to 0, and a new window starts with alignment still sent.
- R6: If the slow attempt also times out, `neg_fail` is high for exactly one cycle. After that the block is idle (`pat_sel`=0, `neg_fail`=0).
- R7: `cfg_cap_low`=1 makes the first attempt start at `tx_rate_hi`=0, so the fast attempt is skipped.
- R8: With `cfg_common`=1 the first attempt starts at the rate given by `peer_rate_hi`. With `cfg_common`=0, `peer_rate_hi` has no effect.
- R9: A reset-burst strobe in any state restarts negotiation: `oob_init_req`=1 and `link_up`=0 in the next cycle.
- R10: Only cycles with `tick`=1 count toward the window. A `cfg_window` of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oob_reset_seen | input | 1 | Strobe: reset/init burst detected from the host |
| oob_wake_seen | input | 1 | Strobe: wake burst detected from the host |
| align_seen | input | 1 | Strobe: alignment primitive detected at the current rate |
| tick | input | 1 | Timer tick |
| cfg_window | input | CW | Number of ticks per rate attempt |
| cfg_cap_low | input | 1 | 1 caps the port at 1.5 Gbps |
| cfg_common | input | 1 | 1 follows the downstream rate |
| peer_rate_hi | input | 1 | Rate negotiated on the downstream side (1 = 3.0 Gbps) |
| tx_rate_hi | output | 1 | Transmit rate select (1 = 3.0 Gbps) |
| pat_sel | output | 2 | Transmit pattern: 0 idle, 1 alignment, 2 data |
| oob_init_req | output | 1 | Request to send an init burst |
| oob_wake_req | output | 1 | Request to send a wake burst |
| neg_rate_hi | output | 1 | Negotiated rate; 1 only while ready at 3.0 Gbps |
| link_up | output | 1 | Negotiation finished |
| neg_fail | output | 1 | One-cycle pulse when both rates failed |

## Verification
The bench sweeps the window length from 0 to 4 against every start-rate choice: capped, common with the peer fast or slow, and free. For each case it confirms an alignment that arrives on the last tick before timeout and one that arrives after the step-down. It also lets both attempts expire. An off-by-one in the tick counter would step down one tick early or late, and treating a window of 0 as a very long window would hang in the fast attempt. The bench also sends strobes in the wrong states and reset bursts out of ready and mid-attempt. A design that leaked those would send alignment before the wake exchange, or stay linked after a new reset burst.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SEND_INIT = 3'd1,
    ST_WAIT_WAKE = 3'd2,
    ST_SEND_WAKE = 3'd3,
    ST_TRY       = 3'd4,
    ST_READY     = 3'd5,
    ST_FAIL      = 3'd6
  } hrs_state_t;

  localparam logic [1:0] PAT_IDLE  = 2'd0;
  localparam logic [1:0] PAT_ALIGN = 2'd1;
  localparam logic [1:0] PAT_DATA  = 2'd2;

  // rate of the first attempt: cap wins, then common-rate follow, else fast
  function automatic logic fn_start_hi(input logic cap_low, input logic common,
                                       input logic peer_hi);
    return !cap_low && (!common || peer_hi);
  endfunction

  // count value on whose tick the window closes (0 behaves like 1)
  function automatic int unsigned fn_window_last(input int unsigned window);
    return (window == 0) ? 0 : window - 1;
  endfunction

endpackage

// File: rtl/hrs_window.sv
module hrs_window #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] window,
  output logic          expire
);
  import hrs_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last   = CW'(fn_window_last(int'(window)));
  assign expire = tick && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  // R10: a cycle without tick never moves the count
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!tick) && $past(!clear)) |-> $stable(cnt));

  // R10: a clear always returns the count to zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/hrs_fsm.sv
module hrs_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oob_reset_seen,
  input  logic               oob_wake_seen,
  input  logic               align_seen,
  input  logic               expire,
  input  logic               start_hi,
  output hrs_pkg::hrs_state_t st,
  output logic               rate_hi,
  output logic               timer_clear
);
  import hrs_pkg::*;

  hrs_state_t nxt;
  logic       step_down;

  assign step_down   = (st == ST_TRY) && !align_seen && expire && rate_hi;
  assign timer_clear = (st != ST_TRY) || step_down;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:      nxt = ST_IDLE;
      ST_SEND_INIT: nxt = ST_WAIT_WAKE;
      ST_WAIT_WAKE: if (oob_wake_seen) nxt = ST_SEND_WAKE;
      ST_SEND_WAKE: nxt = ST_TRY;
      ST_TRY: begin
        if (align_seen)   nxt = ST_READY;
        else if (expire)  nxt = rate_hi ? ST_TRY : ST_FAIL;
      end
      ST_READY:     nxt = ST_READY;
      ST_FAIL:      nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
    if (oob_reset_seen) nxt = ST_SEND_INIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rate_hi <= 1'b1;
    end else begin
      st <= nxt;
      if (st == ST_SEND_WAKE) rate_hi <= start_hi;
      else if (step_down)     rate_hi <= 1'b0;
    end
  end

  // R2: the init burst request lasts one cycle unless a new reset burst arrives
  p_init_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND_INIT && !oob_reset_seen) |=> (st == ST_WAIT_WAKE));

  // R3: an attempt is only entered from the wake reply
  p_try_after_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TRY && $past(st) != ST_TRY) |-> ($past(st) == ST_SEND_WAKE));

  // R4: ready is reached only on an alignment strobe
  p_ready_on_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READY && $past(st) != ST_READY) |-> $past(align_seen));

  // R5: rate falls inside an attempt only at a window expiry
  p_step_on_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TRY && $past(st) == ST_TRY && $fell(rate_hi)) |-> $past(expire));

  // R6: failure lasts one cycle and leads to idle or restart
  p_fail_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAIL) |=> (st == ST_IDLE || st == ST_SEND_INIT));

  // R7: a capped start never attempts the fast rate first
  p_cap_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TRY && $past(st) == ST_SEND_WAKE && $past(!start_hi)) |-> !rate_hi);

  // R9: a reset burst always leads to the init reply
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oob_reset_seen |=> (st == ST_SEND_INIT));

endmodule

// File: rtl/host_rate_stepper.sv
module host_rate_stepper #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oob_reset_seen,
  input  logic          oob_wake_seen,
  input  logic          align_seen,
  input  logic          tick,
  input  logic [CW-1:0] cfg_window,
  input  logic          cfg_cap_low,
  input  logic          cfg_common,
  input  logic          peer_rate_hi,
  output logic          tx_rate_hi,
  output logic [1:0]    pat_sel,
  output logic          oob_init_req,
  output logic          oob_wake_req,
  output logic          neg_rate_hi,
  output logic          link_up,
  output logic          neg_fail
);
  import hrs_pkg::*;

  hrs_state_t st;
  logic       rate_hi;
  logic       timer_clear;
  logic       expire;
  logic       start_hi;

  assign start_hi = fn_start_hi(cfg_cap_low, cfg_common, peer_rate_hi);

  hrs_window #(.CW(CW)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (timer_clear),
    .tick   (tick),
    .window (cfg_window),
    .expire (expire)
  );

  hrs_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .oob_reset_seen (oob_reset_seen),
    .oob_wake_seen  (oob_wake_seen),
    .align_seen     (align_seen),
    .expire         (expire),
    .start_hi       (start_hi),
    .st             (st),
    .rate_hi        (rate_hi),
    .timer_clear    (timer_clear)
  );

  always_comb begin
    case (st)
      ST_TRY:   pat_sel = PAT_ALIGN;
      ST_READY: pat_sel = PAT_DATA;
      default:  pat_sel = PAT_IDLE;
    endcase
  end

  assign tx_rate_hi   = rate_hi;
  assign oob_init_req = (st == ST_SEND_INIT);
  assign oob_wake_req = (st == ST_SEND_WAKE);
  assign link_up      = (st == ST_READY);
  assign neg_rate_hi  = link_up && rate_hi;
  assign neg_fail     = (st == ST_FAIL);

  // R3: alignment is never sent together with a burst request
  p_no_align_with_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oob_init_req || oob_wake_req) |-> (pat_sel == PAT_IDLE));

  // R4: the reported rate matches the line rate while linked
  p_rate_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (neg_rate_hi == tx_rate_hi));

  // R6: failure and link are never flagged together
  p_fail_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({neg_fail, link_up, oob_init_req, oob_wake_req}) <= 1);

endmodule

// File: tb/test_host_rate_stepper.sv
module test_host_rate_stepper;
  localparam int CW     = 8;
  localparam int TCLK   = 10;
  localparam int WDOG   = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          oob_reset_seen = 1'b0, oob_wake_seen = 1'b0, align_seen = 1'b0, tick = 1'b0;
  logic [CW-1:0] cfg_window = 8'd3;
  logic          cfg_cap_low = 1'b0, cfg_common = 1'b0, peer_rate_hi = 1'b0;
  logic          tx_rate_hi, oob_init_req, oob_wake_req, neg_rate_hi, link_up, neg_fail;
  logic [1:0]    pat_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(TCLK/2) clk = ~clk;

  host_rate_stepper #(.CW(CW)) i_host_rate_stepper (
    .clk(clk), .rst_n(rst_n), .oob_reset_seen(oob_reset_seen),
    .oob_wake_seen(oob_wake_seen), .align_seen(align_seen), .tick(tick),
    .cfg_window(cfg_window), .cfg_cap_low(cfg_cap_low), .cfg_common(cfg_common),
    .peer_rate_hi(peer_rate_hi), .tx_rate_hi(tx_rate_hi), .pat_sel(pat_sel),
    .oob_init_req(oob_init_req), .oob_wake_req(oob_wake_req),
    .neg_rate_hi(neg_rate_hi), .link_up(link_up), .neg_fail(neg_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // one cycle with the given strobe pattern, then sample after the edge
  task automatic cyc(input bit r, input bit w, input bit a, input bit t);
    oob_reset_seen = r; oob_wake_seen = w; align_seen = a; tick = t;
    @(negedge clk);
    oob_reset_seen = 0; oob_wake_seen = 0; align_seen = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);
    end
  endtask

  // expected first rate, restated from R7/R8
  function automatic int exp_start();
    if (cfg_cap_low) return 0;
    if (cfg_common)  return peer_rate_hi ? 1 : 0;
    return 1;
  endfunction

  task automatic enter_try();
    cyc(1, 0, 0, 0);
    chk_eq("R2 init req", oob_init_req, 1);
    chk_eq("R9 link drop", link_up, 0);
    cyc(0, 0, 1, 0);
    chk_eq("R2 init one cycle", oob_init_req, 0);
    chk_eq("R3 no align before wake", pat_sel, 0);
    cyc(0, 1, 0, 0);
    chk_eq("R3 wake req", oob_wake_req, 1);
    cyc(0, 0, 0, 0);
    chk_eq("R3 align pattern", pat_sel, 1);
    chk_eq("R5 R7 R8 start rate", tx_rate_hi, exp_start());
  endtask

  initial begin
    #(WDOG * TCLK);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 link_up", link_up, 0);
    chk_eq("R1 neg_fail", neg_fail, 0);
    chk_eq("R1 init req", oob_init_req, 0);
    chk_eq("R1 wake req", oob_wake_req, 0);
    chk_eq("R1 pattern", pat_sel, 0);
    chk_eq("R1 rate", tx_rate_hi, 1);
    rst_n = 1;
    @(negedge clk);
    // R3 stray strobes while idle
    cyc(0, 1, 1, 1);
    chk_eq("R3 idle wake ignored", oob_wake_req, 0);
    chk_eq("R3 idle pattern", pat_sel, 0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      cfg_cap_low  = (cfg == 1);
      cfg_common   = (cfg >= 2);
      peer_rate_hi = (cfg == 3);
      for (int w = 0; w <= 4; w++) begin
        cfg_window = CW'(w);
        wl = (w == 0) ? 1 : w;   // R10 window 0 acts as 1
        // scenario: both attempts time out
        enter_try();
        if (exp_start() == 1) begin
          ticks(wl - 1);
          chk_eq("R5 still fast", tx_rate_hi, 1);
          ticks(1);
          chk_eq("R5 stepped down", tx_rate_hi, 0);
          chk_eq("R5 still aligning", pat_sel, 1);
        end
        ticks(wl - 1);
        chk_eq("R6 no early fail", neg_fail, 0);
        cyc(0, 0, 0, 0);
        chk_eq("R10 idle cycle no expiry", neg_fail, 0);
        cyc(0, 0, 0, 1);
        chk_eq("R6 fail pulse", neg_fail, 1);
        cyc(0, 0, 0, 0);
        chk_eq("R6 fail one cycle", neg_fail, 0);
        chk_eq("R6 back idle", pat_sel, 0);
        // scenario: confirm on last tick before timeout of first attempt
        enter_try();
        ticks(wl - 1);
        cyc(0, 0, 1, 1);
        chk_eq("R4 linked", link_up, 1);
        chk_eq("R4 data pattern", pat_sel, 2);
        chk_eq("R4 rate", neg_rate_hi, exp_start());
        // scenario: confirm after step-down (restart from ready, R9)
        enter_try();
        if (exp_start() == 1) ticks(wl);
        ticks(wl - 1);
        cyc(0, 0, 1, 0);
        chk_eq("R4 linked slow", link_up, 1);
        chk_eq("R4 slow rate", neg_rate_hi, 0);
        cyc(0, 0, 0, 1);
        chk_eq("R4 ready holds", link_up, 1);
      end
    end
    // R8 peer ignored when not common
    cfg_cap_low = 0; cfg_common = 0; peer_rate_hi = 0; cfg_window = 8'd2;
    enter_try();
    chk_eq("R8 peer ignored", tx_rate_hi, 1);
    // R9 reset burst mid-attempt
    ticks(1);
    cyc(1, 0, 0, 0);
    chk_eq("R9 restart init", oob_init_req, 1);
    chk_eq("R9 pattern idle", pat_sel, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule